// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in a wide unpacked form and packs it into the 32-bit IEEE-754 single-precision word. The unpacked form has a class code, a sign, an unbiased exponent, and a mantissa with its leading one at the most significant bit. The bits below the kept fraction are the rounding bits, and a separate sticky input summarises anything already discarded further down. The rounding mode and an underflow-trap-enable bit come in with each value.

For a number, the block biases the exponent. If the biased exponent is zero or negative, it shifts the significand right into the subnormal range. It then rounds through a separate rounding unit and repairs a mantissa that rounds up to 2.0. It detects overflow and underflow and raises the overflow, underflow and inexact flags. Zero, infinity and NaN inputs are passed through as special encodings. The packed word and the flags are registered and appear one clock after a valid input.

Top module: `fp_sgl_pack`

## Requirements
- R1: Class code 0 is zero. Codes 5 to 7 are handled as zero too. The word is the sign in bit 31 with every other bit 0, and no flag is raised.
- R2: Class code 2 is infinity. The word is the sign, exponent field 255 (bits 30:23) and fraction 0 (bits 22:0), with no flags.
- R3: Class codes 3 (quiet NaN) and 4 (signalling NaN) give exponent field 255. The fraction is the 23 mantissa bits just below the leading one, with fraction bit 22 forced to 1. No flags are raised.
- R4: Class code 1 is a number. When the unbiased exponent plus 127 is at least 1, the word is the sign, that biased exponent, and the 23 rounded mantissa bits below the leading one.
- R5: Rounding mode 0 is nearest with ties to even, 1 is toward zero, 2 is toward +infinity and 3 is toward -infinity. Bits below the kept fraction, plus the sticky input, decide whether the fraction is bumped.
- R6: The inexact flag is set whenever a number loses nonzero bits (including sticky) in packing.
- R7: A normal whose rounding carries the mantissa to 2.0 gets its exponent field raised by one and a zero fraction.
- R8: When the biased exponent b is 0 or below, the significand, leading one included, is shifted right by 1-b places before rounding, and the exponent field is 0.
- R9: A subnormal whose rounding carries into fraction bit 23 becomes the smallest normal: exponent field 1, fraction 0, and no underflow flag.
- R10: A result that stays subnormal raises the underflow flag when it is inexact or when the trap-enable input is 1.
- R11: A number whose final biased exponent is 255 or more raises both overflow and inexact.
- R12: On overflow, the word is infinity when the mode is 0, or mode 2 with sign 0, or mode 3 with sign 1. Otherwise it is the largest finite value: exponent field 254 and an all-ones fraction, with the sign kept.
- R13: The outputs are zero after reset. out_valid follows in_valid one cycle later, and the outputs keep their values while in_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input value is present |
| in_class | input | 3 | Class code (0 zero, 1 number, 2 infinity, 3 quiet NaN, 4 signalling NaN) |
| in_sign | input | 1 | Sign |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | MANT_W | Mantissa, leading one at the MSB, rounding bits at the bottom |
| in_sticky | input | 1 | OR of bits discarded below the mantissa |
| in_rmode | input | 2 | Rounding mode |
| in_uf_trap | input | 1 | Underflow trap enable |
| out_valid | output | 1 | Packed result is present |
| out_word | output | 32 | Packed single-precision word |
| out_of | output | 1 | Overflow flag |
| out_uf | output | 1 | Underflow flag |
| out_nx | output | 1 | Inexact flag |

## Verification
The hardest cases to reach from the ports are the two carry repairs. The first is a subnormal that rounds up into the smallest normal. The second is a normal at the top exponent that rounds to 2.0 and only then overflows. Uniform random stimulus almost never hits the one-exponent, all-ones-mantissa windows these need. So the bench aims directed values at exactly those windows in every rounding mode and with both signs. It also biases its random exponents toward the subnormal edge and the overflow edge, where carries and ties happen most often.

// File: rtl/fp_sgl_pkg.sv
package fp_sgl_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fp_class_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_POS  = 2'd2,
    RM_NEG  = 2'd3
  } rmode_e;

  localparam int SGL_FRAC  = 23;
  localparam int SGL_EXPW  = 8;
  localparam int SGL_BIAS  = 127;
  localparam int SGL_EMAX  = 255;

  // decide a bump of the kept lsb from the discarded bits
  function automatic logic f_round_up(input logic lsb, input logic guard,
                                      input logic rest, input logic sign,
                                      input logic [1:0] mode);
    logic lost;
    lost = guard | rest;
    case (mode)
      RM_NEAR: f_round_up = guard & (rest | lsb);
      RM_ZERO: f_round_up = 1'b0;
      RM_POS:  f_round_up = lost & ~sign;
      default: f_round_up = lost & sign;
    endcase
  endfunction

  // overflow saturates to infinity or to the largest finite value
  function automatic logic f_ovf_to_inf(input logic [1:0] mode, input logic sign);
    case (mode)
      RM_NEAR: f_ovf_to_inf = 1'b1;
      RM_ZERO: f_ovf_to_inf = 1'b0;
      RM_POS:  f_ovf_to_inf = ~sign;
      default: f_ovf_to_inf = sign;
    endcase
  endfunction

endpackage

// File: rtl/fp_rnd_unit.sv
module fp_rnd_unit
  import fp_sgl_pkg::*;
(
  input  logic       lsb,
  input  logic       guard,
  input  logic       rest,
  input  logic       sign,
  input  logic [1:0] mode,
  output logic       up,
  output logic       inexact
);
  assign up      = f_round_up(lsb, guard, rest, sign, mode);
  assign inexact = guard | rest;
endmodule

// File: rtl/fp_sgl_align.sv
module fp_sgl_align
  import fp_sgl_pkg::*;
#(
  parameter int MANT_W = 27,
  parameter int EXP_W  = 10,
  localparam int BW     = EXP_W + 2,
  localparam int SH_MAX = MANT_W + 1,
  localparam int SHW    = $clog2(SH_MAX + 1),
  localparam int L      = MANT_W + SH_MAX
)(
  input  logic [EXP_W-1:0]       exp_i,
  input  logic [MANT_W-1:0]      mant_i,
  output logic signed [BW-1:0]   biased_o,
  output logic                   subn_o,
  output logic [SGL_FRAC:0]      sig_o,
  output logic                   guard_o,
  output logic                   rest_o
);
  logic signed [BW-1:0] neg_amt;
  logic [SHW-1:0]       sh_amt;
  logic [L-1:0]         ext;
  logic [L-1:0]         aligned;

  assign biased_o = $signed({{2{exp_i[EXP_W-1]}}, exp_i}) + $signed(BW'(SGL_BIAS));
  assign subn_o   = (biased_o <= $signed(BW'(0)));
  assign neg_amt  = $signed(BW'(1)) - biased_o;

  always_comb begin
    if (!subn_o)
      sh_amt = '0;
    else if (neg_amt > $signed(BW'(SH_MAX)))
      sh_amt = SHW'(SH_MAX);
    else
      sh_amt = neg_amt[SHW-1:0];
  end

  assign ext     = {mant_i, {SH_MAX{1'b0}}};
  assign aligned = ext >> sh_amt;
  assign sig_o   = aligned[L-1 -: SGL_FRAC+1];
  assign guard_o = aligned[L-SGL_FRAC-2];
  assign rest_o  = |aligned[L-SGL_FRAC-3:0];
endmodule

// File: rtl/fp_sgl_pack.sv
module fp_sgl_pack
  import fp_sgl_pkg::*;
#(
  parameter int MANT_W = 27,
  parameter int EXP_W  = 10
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_class,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        in_rmode,
  input  logic              in_uf_trap,
  output logic              out_valid,
  output logic [31:0]       out_word,
  output logic              out_of,
  output logic              out_uf,
  output logic              out_nx
);
  localparam int BW = EXP_W + 2;

  logic signed [BW-1:0] biased;
  logic signed [BW-1:0] exp_fin;
  logic                 subn_w;
  logic [SGL_FRAC:0]    sig;
  logic                 guard_b;
  logic                 rest_b;
  logic                 rest_all;
  logic                 rnd_up;
  logic                 inexact_w;
  logic [SGL_FRAC+1:0]  sum;
  logic                 promote_w;
  logic                 carry2_w;
  logic                 ovf_w;
  logic                 to_inf;
  logic [31:0]          word_d;
  logic                 of_d, uf_d, nx_d;

  fp_sgl_align #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i   (in_exp),
    .mant_i  (in_mant),
    .biased_o(biased),
    .subn_o  (subn_w),
    .sig_o   (sig),
    .guard_o (guard_b),
    .rest_o  (rest_b)
  );

  assign rest_all = rest_b | in_sticky;

  fp_rnd_unit u_rnd (
    .lsb    (sig[0]),
    .guard  (guard_b),
    .rest   (rest_all),
    .sign   (in_sign),
    .mode   (in_rmode),
    .up     (rnd_up),
    .inexact(inexact_w)
  );

  assign sum       = {1'b0, sig} + {{SGL_FRAC+1{1'b0}}, rnd_up};
  assign promote_w = subn_w & sum[SGL_FRAC];
  assign carry2_w  = ~subn_w & sum[SGL_FRAC+1];
  assign exp_fin   = biased + $signed({{BW-1{1'b0}}, carry2_w});
  assign ovf_w     = ~subn_w & (exp_fin >= $signed(BW'(SGL_EMAX)));
  assign to_inf    = f_ovf_to_inf(in_rmode, in_sign);

  always_comb begin
    word_d = {in_sign, 31'd0};
    of_d   = 1'b0;
    uf_d   = 1'b0;
    nx_d   = 1'b0;
    case (in_class)
      CLS_NUM: begin
        nx_d = inexact_w;
        if (subn_w) begin
          if (promote_w) begin
            word_d = {in_sign, 8'd1, 23'd0};
          end else begin
            word_d = {in_sign, 8'd0, sum[SGL_FRAC-1:0]};
            uf_d   = inexact_w | in_uf_trap;
          end
        end else if (ovf_w) begin
          of_d   = 1'b1;
          nx_d   = 1'b1;
          word_d = to_inf ? {in_sign, 8'hFF, 23'd0} : {in_sign, 8'hFE, 23'h7FFFFF};
        end else begin
          word_d = {in_sign, exp_fin[SGL_EXPW-1:0], sum[SGL_FRAC-1:0]};
        end
      end
      CLS_INF:  word_d = {in_sign, 8'hFF, 23'd0};
      CLS_QNAN, CLS_SNAN:
        word_d = {in_sign, 8'hFF, in_mant[MANT_W-2 -: SGL_FRAC] | 23'h400000};
      default:  word_d = {in_sign, 31'd0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
      out_of    <= 1'b0;
      out_uf    <= 1'b0;
      out_nx    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word <= word_d;
        out_of   <= of_d;
        out_uf   <= uf_d;
        out_nx   <= nx_d;
      end
    end
  end
endmodule

// File: rtl/fp_sgl_pack_chk.sv
module fp_sgl_pack_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [2:0]  in_class,
  input logic        in_sign,
  input logic        out_valid,
  input logic [31:0] out_word,
  input logic        out_of,
  input logic        out_uf,
  input logic        out_nx,
  input logic        promote_w,
  input logic        ovf_w
);
  a_r13_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_of_with_nx: assert property (@(posedge clk) disable iff (!rst_n)
    out_of |-> out_nx);

  a_r10_uf_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_uf |-> (out_word[30:23] == 8'd0));

  a_r3_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_class == 3'd3 || in_class == 3'd4)) |=>
      (out_word[30:22] == 9'h1FF) && !out_of && !out_uf && !out_nx);

  a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_class == 3'd0 || in_class > 3'd4)) |=>
      (out_word[30:0] == 31'd0) && !out_of && !out_uf && !out_nx);

  a_r9_promote: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd1 && promote_w) |=>
      (out_word[30:0] == {8'd1, 23'd0}) && !out_uf);

  a_r12_ovf_word: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_class == 3'd1 && ovf_w) |=>
      out_of && (out_word[30:23] >= 8'hFE) && (out_word[31] == $past(in_sign)));
endmodule

bind fp_sgl_pack fp_sgl_pack_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_class (in_class),
  .in_sign  (in_sign),
  .out_valid(out_valid),
  .out_word (out_word),
  .out_of   (out_of),
  .out_uf   (out_uf),
  .out_nx   (out_nx),
  .promote_w(promote_w),
  .ovf_w    (ovf_w)
);

// File: tb/fp_sgl_pack_bench.sv
module fp_sgl_pack_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_class = 3'd0;
  logic        in_sign = 1'b0;
  logic [9:0]  in_exp = 10'd0;
  logic [26:0] in_mant = 27'd0;
  logic        in_sticky = 1'b0;
  logic [1:0]  in_rmode = 2'd0;
  logic        in_uf_trap = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_of, out_uf, out_nx;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fp_sgl_pack u_fp_sgl_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
    .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky),
    .in_rmode(in_rmode), .in_uf_trap(in_uf_trap), .out_valid(out_valid),
    .out_word(out_word), .out_of(out_of), .out_uf(out_uf), .out_nx(out_nx)
  );

  // reference packer: compares the dropped remainder against half an ulp
  function automatic logic [34:0] ref_pack(input int cls, input bit s, input int e,
                                           input longint m, input bit st,
                                           input int mode, input bit trap);
    logic [31:0] w;
    bit of, uf, nx, up;
    int b, d;
    longint kept, rem, tw, h2;
    w = {s, 31'd0}; of = 0; uf = 0; nx = 0;
    if (cls == 2) w = {s, 8'hFF, 23'd0};
    else if (cls == 3 || cls == 4) w = {s, 8'hFF, 23'(m >> 3) | 23'h400000};
    else if (cls == 1) begin
      b = e + 127;
      d = (b >= 1) ? 3 : 4 - b;
      if (d > 60) d = 60;
      kept = m >> d;
      rem  = m & ((64'sd1 <<< d) - 1);
      tw   = rem * 2 + longint'(st);
      h2   = 64'sd1 <<< d;
      nx   = (tw != 0);
      case (mode)
        0: up = (tw > h2) || (tw == h2 && kept[0]);
        1: up = 0;
        2: up = nx && !s;
        default: up = nx && s;
      endcase
      kept = kept + longint'(up);
      if (b < 1) begin
        if (kept == (64'sd1 <<< 23)) w = {s, 8'd1, 23'd0};
        else begin
          w  = {s, 8'd0, kept[22:0]};
          uf = nx | trap;
        end
      end else begin
        if (kept == (64'sd1 <<< 24)) begin b = b + 1; kept = 0; end
        if (b >= 255) begin
          of = 1; nx = 1;
          if (mode == 0 || (mode == 2 && !s) || (mode == 3 && s)) w = {s, 8'hFF, 23'd0};
          else w = {s, 8'hFE, 23'h7FFFFF};
        end else w = {s, 8'(b), kept[22:0]};
      end
    end
    return {of, uf, nx, w};
  endfunction

  function automatic string tag_of(input int cls, input int e, input logic [34:0] r);
    if (cls == 2) return "R2";
    if (cls == 3 || cls == 4) return "R3";
    if (cls != 1) return "R1";
    if (r[34]) return "R11/R12";
    if (e + 127 < 1) return (r[30:23] == 8'd1) ? "R9" : "R8/R10";
    return r[33] ? "R6" : "R4/R5/R7";
  endfunction

  task automatic apply(input int cls, input bit s, input int e, input logic [26:0] m,
                       input bit st, input int mode, input bit trap, input string tag);
    logic [34:0] exp_v;
    logic [34:0] got;
    exp_v = ref_pack(cls, s, e, longint'(m), st, mode, trap);
    in_valid = 1; in_class = 3'(cls); in_sign = s; in_exp = 10'(e);
    in_mant = m; in_sticky = st; in_rmode = 2'(mode); in_uf_trap = trap;
    @(negedge clk);
    in_valid = 0;
    got = {out_of, out_uf, out_nx, out_word};
    checks++;
    if (got !== exp_v || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s %s: cls=%0d e=%0d m=%h mode=%0d got=%h exp=%h valid=%b",
               tag, tag_of(cls, e, exp_v), cls, e, m, mode, got, exp_v, out_valid);
    end
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, out_word, out_of, out_uf, out_nx} !== 36'd0) begin
      fails++;
      $display("FAIL R13 reset: got=%h exp=0", {out_valid, out_word, out_of, out_uf, out_nx});
    end
    rst_n = 1;
    @(negedge clk);

    // directed corners
    apply(0, 1, 5, 27'h5000000, 1, 0, 1, "R1");
    apply(6, 0, 5, 27'h5000000, 0, 0, 0, "R1");
    apply(2, 1, 0, 27'h4000000, 0, 0, 0, "R2");
    apply(3, 0, 0, 27'h4000008, 0, 0, 0, "R3");
    apply(4, 1, 0, 27'h5555558, 0, 0, 0, "R3");
    apply(1, 0, 0, 27'h4000000, 0, 0, 0, "R4");
    apply(1, 0, 0, 27'h4000004, 0, 0, 0, "R5");
    apply(1, 0, 0, 27'h400000C, 0, 0, 0, "R5");
    apply(1, 1, 0, 27'h4000001, 0, 3, 0, "R5");
    apply(1, 0, 0, 27'h4000000, 1, 2, 0, "R6");
    apply(1, 0, 3, 27'h7FFFFFC, 0, 0, 0, "R7");
    apply(1, 0, -130, 27'h4000000, 0, 0, 0, "R8");
    for (int md = 0; md < 4; md++)
      for (int sg = 0; sg < 2; sg++) begin
        apply(1, sg[0], -127, 27'h7FFFFFF, 0, md, 0, "R9");
        apply(1, sg[0], 127, 27'h7FFFFFF, 0, md, 0, "R12");
        apply(1, sg[0], 128, 27'h4000000, 0, md, 0, "R11");
      end
    apply(1, 0, -127, 27'h4000000, 0, 0, 1, "R10");
    apply(1, 0, -127, 27'h4000000, 0, 0, 0, "R10");
    apply(1, 0, -400, 27'h4000000, 0, 2, 0, "R10");

    // hold while idle
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_word !== 32'h7F7FFFFF && out_word !== 32'h00000001) begin
      fails++;
      $display("FAIL R13 hold: valid=%b word=%h exp=0/held", out_valid, out_word);
    end

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int cls, e, r;
      logic [26:0] m;
      r = $urandom % 16;
      cls = (r < 11) ? 1 : (r - 11);
      if (r == 15) cls = 5 + ($urandom % 3);
      case ($urandom % 4)
        0: e = -126 + int'($urandom % 254);
        1: e = -160 + int'($urandom % 36);
        2: e = 120 + int'($urandom % 10);
        default: e = -512 + int'($urandom % 1024);
      endcase
      m = {1'b1, 26'($urandom)};
      if ($urandom % 4 == 0) m[2:0] = 3'b100;
      apply(cls, 1'($urandom), e, m, 1'($urandom % 3 == 0),
            int'($urandom % 4), 1'($urandom), "rand");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule